// File: doc/BRIEF.md
# Composite Video Raster Timing Generator

This block produces the line and field timing of a 525-line or 625-line composite video encoder from a single pixel-rate clock. It counts clocks within each line and lines within each frame, and from those counts it derives the flags that a downstream encoder needs: composite sync, vertical blanking (including the half-line blanking at the end of each frame's last active field line), the burst/clamp gate, the NTSC set-up (pedestal) enable and a horizontal blanking flag. When master timing is selected it also drives horizontal and vertical sync pulses and a 3-bit field sequence count to the video source. The position of the horizontal sync falling edge is programmable relative to the first active sample.

The horizontal position is tracked by a four-state phase machine that walks every line in order: `HP_SYNC` (sync tip) goes to `HP_BACK` after the sync width, `HP_BACK` (back porch with burst) goes to `HP_ACTIVE` at the first active sample, `HP_ACTIVE` goes to `HP_FRONT` after the active width, and `HP_FRONT` returns to `HP_SYNC` at the last clock of the line. A standard request is sampled only when the frame wraps, so a mode change never leaves a partial line or frame behind. The per-line horizontal constants are parameters so the same timing can be built at full 27 MHz values or at reduced line lengths.

Top module: `vid_raster_gen`

## Requirements
- R1: `h_pos` counts 0 to line length minus one and then returns to 0; the line length is `NTSC_LINE` (default 1716) when the standard in force is NTSC and `PAL_LINE` (default 1728) when it is PAL; `h_pos` 0 is the first clock of the sync phase.
- R2: `line_num` counts 1 to 525 (NTSC) or 1 to 625 (PAL), advancing by one when `h_pos` wraps and returning to 1 after the last line.
- R3: During and immediately after reset `line_num` is 64, `h_pos` is 0, `hblank` is 1, `csync_n` is 0, `field_id` is 0 and the standard in force is NTSC.
- R4: `vblank` is 1 on NTSC lines 1 to 9 and 264 to 272 and on PAL lines 1 to 5, 311 to 318 and 624 to 625; on NTSC line 263 and PAL line 623 it is 1 only for `h_pos` at or above half the line length; otherwise it is 0.
- R5: `burst_gate` is 1 only on NTSC lines 10 to 263 or 273 to 525, or PAL lines 6 to 310 or 319 to 623, and only for `h_pos` in [`BURST_START`, `BURST_START+BURST_LEN`).
- R6: `ped_on` is 1 only when the standard is NTSC, `ped_en` is 1, the line is 23 to 262 or 286 to 525, and `h_pos` is in the active region.
- R7: On ordinary lines `csync_n` is 0 for `h_pos` below `SYNC_W` and 1 elsewhere; on vertical sync lines (NTSC 4 to 6 and 267 to 269, PAL 1 to 3 and 313 to 315) it is 1 only in the last `SYNC_W` clocks of each half line and 0 elsewhere.
- R8: `field_id` increments by one when line 1 begins and when the second field's first line (NTSC 264, PAL 313) begins, wrapping modulo 4 under NTSC and modulo 8 under PAL, the modulus taken from the standard of the line being entered.
- R9: `std_sel` (0 NTSC, 1 PAL) takes effect only when the frame wraps to line 1; earlier lines keep the previous standard's line length and line count.
- R10: With `master_en` 1, `hs_n` falls at `h_pos` equal to (active start minus `hs_offset`) modulo the line length and stays 0 for `SYNC_W` clocks; active start is `NTSC_ACT` or `PAL_ACT`; `hs_offset` must be below the line length.
- R11: With `master_en` 1, `vs_n` is 0 exactly on the vertical sync lines of R7 and `fc_out` equals `field_id`; with `master_en` 0, `hs_n` and `vs_n` are 1 and `fc_out` is 0.
- R12: `hblank` is 0 exactly for `h_pos` in [active start, active start plus `ACT_W`) and 1 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | Requested standard, 0 NTSC, 1 PAL |
| ped_en | input | 1 | Enables the NTSC set-up flag |
| master_en | input | 1 | Drives sync and field outputs when 1 |
| hs_offset | input | HOFF_W | Clocks from HS falling edge to first active sample |
| h_pos | output | H_W | Clock position within the line |
| line_num | output | 10 | Line number, 1-based |
| field_id | output | 3 | Field sequence count |
| hblank | output | 1 | Horizontal blanking flag |
| vblank | output | 1 | Vertical blanking flag |
| csync_n | output | 1 | Composite sync, active low |
| burst_gate | output | 1 | Burst/clamp gate |
| ped_on | output | 1 | NTSC set-up enable flag |
| hs_n | output | 1 | Master horizontal sync, active low |
| vs_n | output | 1 | Master vertical sync, active low |
| fc_out | output | 3 | Master field count output |

## Verification
On every cycle the assertions hold the horizontal counter inside the current line length, keep the phase machine consistent with that counter, hold the line number inside the frame, keep the standard fixed except at a frame wrap, bound the field count under NTSC, and confirm that set-up and burst only appear in blanking-consistent places and that slave mode leaves the sync outputs idle. The exact line windows of blanking, burst and set-up, the half-line blanking edge, the broad-pulse shape of vertical sync lines, the field counter's modulus across a standard change and the placement of the HS edge for a given offset can only be shown by the bench's directed scenarios, which step to specific line and clock positions and compare against the requirement values.

// File: rtl/vrg_pkg.sv
package vrg_pkg;

    typedef enum logic {
        STD_NTSC = 1'b0,
        STD_PAL  = 1'b1
    } vid_std_e;

    typedef enum logic [1:0] {
        HP_SYNC,
        HP_BACK,
        HP_ACTIVE,
        HP_FRONT
    } hphase_e;

    localparam int LINE_W = 10;
    localparam int FC_W   = 3;

    function automatic logic [LINE_W-1:0] frame_lines(vid_std_e s);
        return (s == STD_PAL) ? 10'd625 : 10'd525;
    endfunction

    function automatic logic [LINE_W-1:0] second_field_line(vid_std_e s);
        return (s == STD_PAL) ? 10'd313 : 10'd264;
    endfunction

    function automatic logic in_range(logic [LINE_W-1:0] l, logic [LINE_W-1:0] lo,
                                      logic [LINE_W-1:0] hi);
        return (l >= lo) && (l <= hi);
    endfunction

    function automatic logic full_blank_line(vid_std_e s, logic [LINE_W-1:0] l);
        if (s == STD_PAL)
            return in_range(l, 10'd1, 10'd5) || in_range(l, 10'd311, 10'd318) ||
                   in_range(l, 10'd624, 10'd625);
        return in_range(l, 10'd1, 10'd9) || in_range(l, 10'd264, 10'd272);
    endfunction

    function automatic logic half_blank_line(vid_std_e s, logic [LINE_W-1:0] l);
        return (s == STD_PAL) ? (l == 10'd623) : (l == 10'd263);
    endfunction

    function automatic logic burst_line(vid_std_e s, logic [LINE_W-1:0] l);
        if (s == STD_PAL)
            return in_range(l, 10'd6, 10'd310) || in_range(l, 10'd319, 10'd623);
        return in_range(l, 10'd10, 10'd263) || in_range(l, 10'd273, 10'd525);
    endfunction

    function automatic logic setup_line(vid_std_e s, logic [LINE_W-1:0] l);
        if (s == STD_PAL)
            return 1'b0;
        return in_range(l, 10'd23, 10'd262) || in_range(l, 10'd286, 10'd525);
    endfunction

    function automatic logic vsync_line(vid_std_e s, logic [LINE_W-1:0] l);
        if (s == STD_PAL)
            return in_range(l, 10'd1, 10'd3) || in_range(l, 10'd313, 10'd315);
        return in_range(l, 10'd4, 10'd6) || in_range(l, 10'd267, 10'd269);
    endfunction

    function automatic logic [FC_W-1:0] field_step(logic [FC_W-1:0] f, vid_std_e s);
        logic [FC_W-1:0] n;
        n = f + 3'd1;
        return (s == STD_PAL) ? n : {1'b0, n[1:0]};
    endfunction

endpackage

// File: rtl/vrg_hphase.sv
module vrg_hphase
    import vrg_pkg::*;
#(
    parameter int NTSC_LINE = 1716,
    parameter int PAL_LINE  = 1728,
    parameter int SYNC_W    = 127,
    parameter int NTSC_ACT  = 244,
    parameter int PAL_ACT   = 264,
    parameter int ACT_W     = 1440,
    parameter int H_W       = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  vid_std_e       std,
    output logic [H_W-1:0] h_pos,
    output hphase_e        phase,
    output logic           line_end
);

    localparam logic [H_W-1:0] N_LAST    = H_W'(NTSC_LINE - 1);
    localparam logic [H_W-1:0] P_LAST    = H_W'(PAL_LINE - 1);
    localparam logic [H_W-1:0] SYNC_LAST = H_W'(SYNC_W - 1);
    localparam logic [H_W-1:0] N_ACT     = H_W'(NTSC_ACT);
    localparam logic [H_W-1:0] P_ACT     = H_W'(PAL_ACT);
    localparam logic [H_W-1:0] ACT_SPAN  = H_W'(ACT_W);

    logic [H_W-1:0] last_h;
    logic [H_W-1:0] act_start;
    logic [H_W-1:0] act_stop;
    hphase_e        phase_nx;

    assign last_h    = (std == STD_PAL) ? P_LAST : N_LAST;
    assign act_start = (std == STD_PAL) ? P_ACT : N_ACT;
    assign act_stop  = act_start + ACT_SPAN;
    assign line_end  = (h_pos == last_h);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            h_pos <= '0;
        else if (line_end)
            h_pos <= '0;
        else
            h_pos <= h_pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= HP_SYNC;
        else
            phase <= phase_nx;
    end

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            HP_SYNC:   if (h_pos == SYNC_LAST)         phase_nx = HP_BACK;
            HP_BACK:   if (h_pos == act_start - 1'b1)  phase_nx = HP_ACTIVE;
            HP_ACTIVE: if (h_pos == act_stop - 1'b1)   phase_nx = HP_FRONT;
            HP_FRONT:  if (line_end)                   phase_nx = HP_SYNC;
        endcase
    end

    AST_H_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        h_pos <= last_h); // R1
    AST_SYNC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos == '0) |-> (phase == HP_SYNC)); // R1
    AST_ACTIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == HP_ACTIVE) |-> ((h_pos >= act_start) && (h_pos < act_stop))); // R12

endmodule

// File: rtl/vrg_vcount.sv
module vrg_vcount
    import vrg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  vid_std_e          std_req,
    output vid_std_e          std,
    output logic [LINE_W-1:0] line_num,
    output logic [FC_W-1:0]   field_id
);

    localparam logic [LINE_W-1:0] RESET_LINE = 10'd64;

    logic frame_end;
    logic [LINE_W-1:0] line_inc;

    assign frame_end = line_end && (line_num == frame_lines(std));
    assign line_inc  = line_num + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            std      <= STD_NTSC;
            line_num <= RESET_LINE;
            field_id <= '0;
        end else if (frame_end) begin
            std      <= std_req;
            line_num <= 10'd1;
            field_id <= field_step(field_id, std_req);
        end else if (line_end) begin
            line_num <= line_inc;
            if (line_inc == second_field_line(std))
                field_id <= field_step(field_id, std);
        end
    end

    AST_STD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(std)); // R9
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num >= 10'd1) && (line_num <= frame_lines(std))); // R2
    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(line_num)); // R2
    AST_FIELD_NTSC_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (std == STD_NTSC) |-> (field_id < 3'd4)); // R8

endmodule

// File: rtl/vrg_decode.sv
module vrg_decode
    import vrg_pkg::*;
#(
    parameter int NTSC_LINE   = 1716,
    parameter int PAL_LINE    = 1728,
    parameter int SYNC_W      = 127,
    parameter int NTSC_ACT    = 244,
    parameter int PAL_ACT     = 264,
    parameter int BURST_START = 148,
    parameter int BURST_LEN   = 64,
    parameter int HOFF_W      = 10,
    parameter int H_W         = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vid_std_e          std,
    input  logic [LINE_W-1:0] line_num,
    input  logic [H_W-1:0]    h_pos,
    input  hphase_e           phase,
    input  logic              ped_en,
    input  logic              master_en,
    input  logic [HOFF_W-1:0] hs_offset,
    output logic              hblank,
    output logic              vblank,
    output logic              csync_n,
    output logic              burst_gate,
    output logic              ped_on,
    output logic              hs_n,
    output logic              vs_n
);

    int  hi, len, half, act, fall, diff;
    logic vs_line;

    always_comb begin
        hi      = int'(h_pos);
        len     = (std == STD_PAL) ? PAL_LINE : NTSC_LINE;
        act     = (std == STD_PAL) ? PAL_ACT : NTSC_ACT;
        half    = len / 2;
        vs_line = vsync_line(std, line_num);

        hblank     = (phase != HP_ACTIVE);
        vblank     = full_blank_line(std, line_num) ||
                     (half_blank_line(std, line_num) && (hi >= half));
        burst_gate = burst_line(std, line_num) && (hi >= BURST_START) &&
                     (hi < BURST_START + BURST_LEN);
        ped_on     = ped_en && setup_line(std, line_num) && (phase == HP_ACTIVE);

        if (vs_line)
            csync_n = ((hi >= half - SYNC_W) && (hi < half)) || (hi >= len - SYNC_W);
        else
            csync_n = (phase != HP_SYNC);

        fall = act + len - int'(hs_offset);
        if (fall >= len)
            fall = fall - len;
        diff = hi - fall;
        if (diff < 0)
            diff = diff + len;

        hs_n = !(master_en && (diff < SYNC_W));
        vs_n = !(master_en && vs_line);
    end

    AST_SETUP_NTSC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ped_on |-> ((std == STD_NTSC) && ped_en && !vblank && !hblank)); // R6
    AST_BURST_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        burst_gate |-> (hblank && !vblank)); // R5
    AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (hs_n && vs_n)); // R11

endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
    import vrg_pkg::*;
#(
    parameter int NTSC_LINE   = 1716,
    parameter int PAL_LINE    = 1728,
    parameter int SYNC_W      = 127,
    parameter int NTSC_ACT    = 244,
    parameter int PAL_ACT     = 264,
    parameter int ACT_W       = 1440,
    parameter int BURST_START = 148,
    parameter int BURST_LEN   = 64,
    parameter int HOFF_W      = 10,
    localparam int H_W        = $clog2((NTSC_LINE > PAL_LINE) ? NTSC_LINE : PAL_LINE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              std_sel,
    input  logic              ped_en,
    input  logic              master_en,
    input  logic [HOFF_W-1:0] hs_offset,
    output logic [H_W-1:0]    h_pos,
    output logic [9:0]        line_num,
    output logic [2:0]        field_id,
    output logic              hblank,
    output logic              vblank,
    output logic              csync_n,
    output logic              burst_gate,
    output logic              ped_on,
    output logic              hs_n,
    output logic              vs_n,
    output logic [2:0]        fc_out
);

    vid_std_e std_now;
    hphase_e  phase;
    logic     line_end;

    vrg_hphase #(
        .NTSC_LINE(NTSC_LINE), .PAL_LINE(PAL_LINE), .SYNC_W(SYNC_W),
        .NTSC_ACT(NTSC_ACT), .PAL_ACT(PAL_ACT), .ACT_W(ACT_W), .H_W(H_W)
    ) u_hphase (
        .clk(clk), .rst_n(rst_n), .std(std_now),
        .h_pos(h_pos), .phase(phase), .line_end(line_end)
    );

    vrg_vcount u_vcount (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .std_req(vid_std_e'(std_sel)), .std(std_now),
        .line_num(line_num), .field_id(field_id)
    );

    vrg_decode #(
        .NTSC_LINE(NTSC_LINE), .PAL_LINE(PAL_LINE), .SYNC_W(SYNC_W),
        .NTSC_ACT(NTSC_ACT), .PAL_ACT(PAL_ACT), .BURST_START(BURST_START),
        .BURST_LEN(BURST_LEN), .HOFF_W(HOFF_W), .H_W(H_W)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .std(std_now), .line_num(line_num),
        .h_pos(h_pos), .phase(phase), .ped_en(ped_en), .master_en(master_en),
        .hs_offset(hs_offset), .hblank(hblank), .vblank(vblank),
        .csync_n(csync_n), .burst_gate(burst_gate), .ped_on(ped_on),
        .hs_n(hs_n), .vs_n(vs_n)
    );

    assign fc_out = master_en ? field_id : 3'd0;

    AST_RESET_LINE: assert property (@(posedge clk)
        !rst_n |=> (line_num == 10'd64) || !rst_n); // R3

endmodule

// File: tb/vid_raster_gen_bench.sv
module vid_raster_gen_bench;

    localparam int NL = 24;
    localparam int PL = 28;
    localparam int SW = 3;
    localparam int NA = 8;
    localparam int PA = 9;
    localparam int AW = 12;
    localparam int BS = 4;
    localparam int BL = 2;
    localparam int HW = $clog2(PL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          std_sel = 1'b0;
    logic          ped_en = 1'b1;
    logic          master_en = 1'b0;
    logic [9:0]    hs_offset = '0;
    logic [HW-1:0] h_pos;
    logic [9:0]    line_num;
    logic [2:0]    field_id;
    logic          hblank, vblank, csync_n, burst_gate, ped_on, hs_n, vs_n;
    logic [2:0]    fc_out;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vid_raster_gen #(
        .NTSC_LINE(NL), .PAL_LINE(PL), .SYNC_W(SW), .NTSC_ACT(NA), .PAL_ACT(PA),
        .ACT_W(AW), .BURST_START(BS), .BURST_LEN(BL), .HOFF_W(10)
    ) u_vid_raster_gen (
        .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .ped_en(ped_en),
        .master_en(master_en), .hs_offset(hs_offset), .h_pos(h_pos),
        .line_num(line_num), .field_id(field_id), .hblank(hblank),
        .vblank(vblank), .csync_n(csync_n), .burst_gate(burst_gate),
        .ped_on(ped_on), .hs_n(hs_n), .vs_n(vs_n), .fc_out(fc_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic goto(input int l, input int h);
        int n = 0;
        while (!(int'(line_num) == l && int'(h_pos) == h) && n < 40000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 40000) chk($sformatf("R2 reach line %0d h %0d", l, h), 0, 1);
    endtask

    task automatic t_reset;
        chk("R3 reset line", int'(line_num), 64);
        chk("R3 reset h", int'(h_pos), 0);
        chk("R3 reset hblank", int'(hblank), 1);
        chk("R3 reset csync", int'(csync_n), 0);
        chk("R3 reset field", int'(field_id), 0);
        chk("R11 slave fc_out", int'(fc_out), 0);
        chk("R11 slave hs_n", int'(hs_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 h after release", int'(h_pos), 1);
        chk("R3 line after release", int'(line_num), 64);
    endtask

    task automatic t_hline;
        goto(64, 2);  chk("R7 sync tip end", int'(csync_n), 0);
        goto(64, 3);  chk("R7 after sync", int'(csync_n), 1);
        goto(64, 7);  chk("R12 before active", int'(hblank), 1);
        goto(64, 8);  chk("R12 active start", int'(hblank), 0);
                      chk("R6 setup line 64", int'(ped_on), 1);
        goto(64, 19); chk("R12 active last", int'(hblank), 0);
        goto(64, 20); chk("R12 front porch", int'(hblank), 1);
        goto(64, 23); @(negedge clk);
        chk("R1 ntsc wrap h", int'(h_pos), 0);
        chk("R2 line step", int'(line_num), 65);
    endtask

    task automatic t_ntsc_vert;
        goto(262, 8);  chk("R6 line 262", int'(ped_on), 1);
        goto(263, 4);  chk("R5 line 263 burst", int'(burst_gate), 1);
        goto(263, 5);  chk("R5 burst last", int'(burst_gate), 1);
        goto(263, 6);  chk("R5 burst end", int'(burst_gate), 0);
        goto(263, 8);  chk("R6 line 263", int'(ped_on), 0);
        goto(263, 11); chk("R4 half first", int'(vblank), 0);
        goto(263, 12); chk("R4 half second", int'(vblank), 1);
        goto(264, 0);  chk("R4 line 264", int'(vblank), 1);
                       chk("R8 field two start", int'(field_id), 1);
        goto(264, 4);  chk("R5 line 264", int'(burst_gate), 0);
        goto(272, 0);  chk("R4 line 272", int'(vblank), 1);
        goto(273, 0);  chk("R4 line 273", int'(vblank), 0);
        goto(273, 4);  chk("R5 line 273", int'(burst_gate), 1);
        goto(285, 8);  chk("R6 line 285", int'(ped_on), 0);
        goto(286, 8);  chk("R6 line 286", int'(ped_on), 1);
        ped_en = 1'b0;
        goto(300, 8);  chk("R6 ped disabled", int'(ped_on), 0);
        ped_en = 1'b1;
        goto(525, 23); @(negedge clk);
        chk("R2 ntsc frame wrap", int'(line_num), 1);
        chk("R8 frame start", int'(field_id), 2);
        goto(4, 0);  chk("R7 vsync low", int'(csync_n), 0);
        goto(4, 10); chk("R7 vsync mid high", int'(csync_n), 1);
        goto(4, 12); chk("R7 vsync half low", int'(csync_n), 0);
        goto(4, 20); chk("R7 vsync late low", int'(csync_n), 0);
        goto(4, 21); chk("R7 vsync end high", int'(csync_n), 1);
        goto(9, 4);  chk("R5 line 9", int'(burst_gate), 0);
                     chk("R4 line 9", int'(vblank), 1);
        goto(10, 4); chk("R5 line 10", int'(burst_gate), 1);
                     chk("R4 line 10", int'(vblank), 0);
        goto(22, 8); chk("R6 line 22", int'(ped_on), 0);
        goto(23, 8); chk("R6 line 23", int'(ped_on), 1);
    endtask

    task automatic t_std_switch;
        goto(264, 0); chk("R8 field three", int'(field_id), 3);
        goto(300, 0);
        std_sel = 1'b1;
        goto(301, 23); @(negedge clk);
        chk("R9 old length kept", int'(line_num), 302);
        chk("R9 old length h", int'(h_pos), 0);
        goto(525, 23); @(negedge clk);
        chk("R9 old count kept", int'(line_num), 1);
        chk("R8 mod8 after switch", int'(field_id), 4);
        goto(1, 27); chk("R1 pal length", int'(h_pos), 27);
        @(negedge clk);
        chk("R1 pal wrap", int'(line_num), 2);
    endtask

    task automatic t_pal_vert;
        goto(5, 0);    chk("R4 pal line 5", int'(vblank), 1);
        goto(6, 0);    chk("R4 pal line 6", int'(vblank), 0);
        goto(6, 4);    chk("R5 pal line 6", int'(burst_gate), 1);
        goto(100, 9);  chk("R6 pal no setup", int'(ped_on), 0);
                       chk("R12 pal active start", int'(hblank), 0);
        goto(310, 4);  chk("R5 pal line 310", int'(burst_gate), 1);
        goto(311, 0);  chk("R4 pal line 311", int'(vblank), 1);
        goto(311, 4);  chk("R5 pal line 311", int'(burst_gate), 0);
        goto(313, 0);  chk("R8 pal field two", int'(field_id), 5);
        goto(318, 0);  chk("R4 pal line 318", int'(vblank), 1);
        goto(319, 0);  chk("R4 pal line 319", int'(vblank), 0);
        goto(319, 4);  chk("R5 pal line 319", int'(burst_gate), 1);
        goto(623, 4);  chk("R5 pal line 623", int'(burst_gate), 1);
        goto(623, 13); chk("R4 pal half first", int'(vblank), 0);
        goto(623, 14); chk("R4 pal half second", int'(vblank), 1);
        goto(624, 0);  chk("R4 pal line 624", int'(vblank), 1);
        goto(625, 27); @(negedge clk);
        chk("R2 pal frame wrap", int'(line_num), 1);
        chk("R8 pal field six", int'(field_id), 6);
    endtask

    task automatic t_master;
        master_en = 1'b1;
        hs_offset = 10'd2;
        goto(2, 0);  chk("R11 vs low", int'(vs_n), 0);
                     chk("R11 fc_out", int'(fc_out), 6);
                     chk("R7 pal vsync low", int'(csync_n), 0);
        goto(2, 11); chk("R7 pal vsync mid", int'(csync_n), 1);
        goto(2, 25); chk("R7 pal vsync end", int'(csync_n), 1);
        goto(4, 0);  chk("R11 vs released", int'(vs_n), 1);
        goto(5, 6);  chk("R10 before fall", int'(hs_n), 1);
        goto(5, 7);  chk("R10 fall", int'(hs_n), 0);
        goto(5, 9);  chk("R10 held", int'(hs_n), 0);
        goto(5, 10); chk("R10 rise", int'(hs_n), 1);
        goto(6, 0);
        hs_offset = 10'd12;
        goto(6, 24); chk("R10 wrap before", int'(hs_n), 1);
        goto(6, 25); chk("R10 wrap fall", int'(hs_n), 0);
        goto(6, 27); chk("R10 wrap held", int'(hs_n), 0);
        @(negedge clk);
        chk("R10 wrap rise", int'(hs_n), 1);
        goto(313, 0); chk("R8 field seven", int'(fc_out), 7);
        goto(625, 27); @(negedge clk);
        chk("R8 pal mod8 wrap", int'(field_id), 0);
        chk("R11 fc_out wrap", int'(fc_out), 0);
        goto(1, 5);
        master_en = 1'b0;
        hs_offset = 10'd2;
        goto(1, 10);
        chk("R11 slave fc_out zero", int'(fc_out), 0);
        goto(2, 7);  chk("R11 slave hs idle", int'(hs_n), 1);
                     chk("R11 slave vs idle", int'(vs_n), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_hline();
        t_ntsc_vert();
        t_std_switch();
        t_pal_vert();
        t_master();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk("R1 watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule